// File: doc/BRIEF.md
# Rewindable Bus-Master Write FIFO

This block buffers write data on its way to a bus master. Words are pushed into a RAM through a write address counter. The head word is moved ahead of time into an output holding register, so it is ready when the bus cycle starts. From that moment the word no longer counts as part of the FIFO. When the target takes the word (`accept`), the read address counter advances and the next word is loaded into the holding register on the same clock edge. This keeps back-to-back transfers at one word per cycle.

The target can end the transaction without taking the held word (`disconnect`). The read address counter then counts down by one, so the same word is loaded and offered again. For a data source that can be fetched again, `flush` throws away everything that is buffered and the word that is held. The reset input is asynchronous and active low, and the block releases it synchronously inside.

Top module: `rwnd_wfifo`

## Requirements
- R1: After reset, `out_valid` is 0, `count` is 0, `empty` is 1 and `full` is 0.
- R2: `wr_en` with `full` low stores `wr_data` and raises `count` by one. `wr_en` with `full` high is dropped, so the dropped word never reaches `out_data`.
- R3: While `out_valid` is low and the FIFO is not empty at the start of a cycle, the oldest word is moved into the holding register at that cycle's edge. `out_valid` rises and `count` falls by one. A word written in a given cycle can appear on `out_data` at the second edge after the write at the earliest. While `out_valid` is high and nothing else happens, `out_data` holds its value.
- R4: `accept` with `out_valid` high loads the next word in the same cycle if the FIFO is not empty. If the FIFO is empty, `out_valid` drops. Words come out in write order.
- R5: `disconnect` with `out_valid` high and `accept` low is a rewind. The next cycle shows `out_valid` low and `count` one higher. The cycle after that shows the same word again on `out_data`.
- R6: `accept` or `disconnect` with `out_valid` low has no effect. When `accept` and `disconnect` are both high, the cycle is treated as an accept.
- R7: `flush` takes priority over `accept` and `disconnect`. The next cycle shows `out_valid` low and `count` 0. A write issued in the same cycle as the flush is kept and is counted.
- R8: `full` is high when `count` plus the held word equals DEPTH. A rewind never loses a word. `empty` is high exactly when `count` is 0.
- R9: Order is kept when the address counters wrap past the end of the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` |
| wr_data | input | DATA_W | Word to store |
| accept | input | 1 | Target took the held word |
| disconnect | input | 1 | Target ended without taking the held word |
| flush | input | 1 | Discard all buffered data and the held word |
| out_data | output | DATA_W | Held word |
| out_valid | output | 1 | Holding register contains a word |
| full | output | 1 | No room for another write |
| empty | output | 1 | RAM holds no word |
| count | output | ADDR_W+1 | Words in RAM, not counting the held word |

## Verification
Bursts of accepts across several words show that the held word is replaced on the accept edge, with no bubble, and in write order. A long stream of single words shows that the address counters wrap correctly. Filling the FIFO past capacity and then draining it separates correct full detection from silent overwrites of the held slot. A rewind at the full point shows that the backed-up word survives. A rewind, a lone accept or disconnect while nothing is held, and a flush combined with accept, disconnect and a write tell apart the priorities among the controls.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  typedef enum logic [2:0] {
    RD_HOLD,
    RD_LOAD,
    RD_DRAIN,
    RD_REWIND,
    RD_FLUSH
  } rd_op_e;
endpackage

// File: rtl/rwf_rst_sync.sv
module rwf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/rwf_ram.sv
module rwf_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rwf_wptr.sv
module rwf_wptr #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (inc) begin
      ptr_d = ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (inc) begin
      ptr <= ptr_d;
    end
  end
endmodule

// File: rtl/rwf_rptr.sv
module rwf_rptr #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             sync,
  input  logic [PTR_W-1:0] sync_val,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  assign ptr_en = inc | dec | sync;

  always_comb begin
    ptr_d = ptr;
    if (sync) begin
      ptr_d = sync_val;
    end else if (dec) begin
      ptr_d = ptr - PTR_W'(1);
    end else if (inc) begin
      ptr_d = ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_en) begin
      ptr <= ptr_d;
    end
  end
endmodule

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
  import rwf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              disconnect,
  input  logic              flush,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] head_word,
  output logic              rp_inc,
  output logic              rp_dec,
  output logic              rp_sync,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  rd_op_e            op;
  logic              valid_d;
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    if (flush) begin
      op = RD_FLUSH;
    end else if (out_valid && accept) begin
      op = fifo_empty ? RD_DRAIN : RD_LOAD;
    end else if (out_valid && disconnect) begin
      op = RD_REWIND;
    end else if (!out_valid && !fifo_empty) begin
      op = RD_LOAD;
    end else begin
      op = RD_HOLD;
    end
  end

  always_comb begin
    valid_d = out_valid;
    data_d  = out_data;
    data_en = 1'b0;
    unique case (op)
      RD_LOAD: begin
        valid_d = 1'b1;
        data_d  = head_word;
        data_en = 1'b1;
      end
      RD_DRAIN, RD_REWIND, RD_FLUSH: valid_d = 1'b0;
      default: ;
    endcase
  end

  assign rp_inc  = (op == RD_LOAD);
  assign rp_dec  = (op == RD_REWIND);
  assign rp_sync = (op == RD_FLUSH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (data_en) begin
      out_data <= data_d;
    end
  end
endmodule

// File: rtl/rwnd_wfifo.sv
module rwnd_wfifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              accept,
  input  logic              disconnect,
  input  logic              flush,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              full,
  output logic              empty,
  output logic [PTR_W-1:0]  count
);
  logic              rst_int_n;
  logic [PTR_W-1:0]  wptr;
  logic [PTR_W-1:0]  rptr;
  logic              wr_go;
  logic              rp_inc;
  logic              rp_dec;
  logic              rp_sync;
  logic [DATA_W-1:0] head_word;

  rwf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign count = wptr - rptr;
  assign empty = (count == '0);
  // The held word's slot stays reserved so a rewind can reread it.
  assign full  = (count == PTR_W'(DEPTH)) ||
                 (out_valid && (count == PTR_W'(DEPTH - 1)));
  assign wr_go = wr_en && !full;

  rwf_wptr #(.PTR_W(PTR_W)) u_wptr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .inc   (wr_go),
    .ptr   (wptr)
  );

  rwf_rptr #(.PTR_W(PTR_W)) u_rptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .inc      (rp_inc),
    .dec      (rp_dec),
    .sync     (rp_sync),
    .sync_val (wptr),
    .ptr      (rptr)
  );

  rwf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wptr[ADDR_W-1:0]),
    .wdata (wr_data),
    .raddr (rptr[ADDR_W-1:0]),
    .rdata (head_word)
  );

  rwf_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .disconnect (disconnect),
    .flush      (flush),
    .fifo_empty (empty),
    .head_word  (head_word),
    .rp_inc     (rp_inc),
    .rp_dec     (rp_dec),
    .rp_sync    (rp_sync),
    .out_data   (out_data),
    .out_valid  (out_valid)
  );
endmodule

// File: rtl/rwf_chk.sv
module rwf_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              accept,
  input logic              disconnect,
  input logic              flush,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              full,
  input logic              empty,
  input logic [PTR_W-1:0]  count
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !accept && !disconnect && !flush |=> out_valid && $stable(out_data));

  p_accept_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && accept && !flush && !empty |=> out_valid);

  p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && disconnect && !accept && !flush && !wr_en
    |=> !out_valid && (count == $past(count) + PTR_W'(1)));

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !wr_en |=> !out_valid && empty);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(count) + 32'(out_valid)) <= DEPTH);

  p_drop_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full && out_valid && wr_en && !accept && !disconnect && !flush |=> $stable(count));
endmodule

bind rwnd_wfifo rwf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .accept     (accept),
  .disconnect (disconnect),
  .flush      (flush),
  .out_data   (out_data),
  .out_valid  (out_valid),
  .full       (full),
  .empty      (empty),
  .count      (count)
);

// File: tb/rwnd_wfifo_tb.sv
module rwnd_wfifo_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int PTR_W  = $clog2(DEPTH) + 1;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              accept;
  logic              disconnect;
  logic              flush;
  logic [DATA_W-1:0] out_data;
  logic              out_valid;
  logic              full;
  logic              empty;
  logic [PTR_W-1:0]  count;

  int n_checks;
  int n_fail;

  rwnd_wfifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .accept     (accept),
    .disconnect (disconnect),
    .flush      (flush),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .full       (full),
    .empty      (empty),
    .count      (count)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    wr_en = 1'b0; accept = 1'b0; disconnect = 1'b0; flush = 1'b0;
  endtask

  task automatic clean();
    idle_inputs();
    flush = 1'b1;
    cyc();
    idle_inputs();
    cyc();
  endtask

  task automatic push(input int v);
    wr_en = 1'b1; wr_data = DATA_W'(v);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 count", int'(count), 0);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
  endtask

  task automatic t_order();
    clean();
    push(101); push(102); push(103);
    // word 101 was loaded on the edge after the second push
    chk("R3 out_valid", int'(out_valid), 1);
    chk("R3 out_data", int'(out_data), 101);
    chk("R3 count", int'(count), 2);
    cyc();
    chk("R3 hold data", int'(out_data), 101);
    accept = 1'b1; cyc();
    chk("R4 next word", int'(out_data), 102);
    chk("R4 valid kept", int'(out_valid), 1);
    cyc();
    chk("R4 third word", int'(out_data), 103);
    chk("R4 count zero", int'(count), 0);
    cyc();
    chk("R4 drained valid", int'(out_valid), 0);
    accept = 1'b0;
  endtask

  task automatic t_rewind();
    clean();
    push(201); push(202);
    chk("R5 loaded", int'(out_data), 201);
    chk("R5 count before", int'(count), 1);
    disconnect = 1'b1; cyc(); disconnect = 1'b0;
    chk("R5 valid dropped", int'(out_valid), 0);
    chk("R5 count up", int'(count), 2);
    cyc();
    chk("R5 same word", int'(out_data), 201);
    chk("R5 revalid", int'(out_valid), 1);
    accept = 1'b1; cyc(); accept = 1'b0;
    chk("R5 then next", int'(out_data), 202);
  endtask

  task automatic t_ignored();
    clean();
    accept = 1'b1; disconnect = 1'b1; cyc(); idle_inputs();
    chk("R6 idle count", int'(count), 0);
    chk("R6 idle valid", int'(out_valid), 0);
    push(301); push(302);
    accept = 1'b1; disconnect = 1'b1; cyc(); idle_inputs();
    chk("R6 accept wins data", int'(out_data), 302);
    chk("R6 accept wins count", int'(count), 0);
  endtask

  task automatic t_full();
    clean();
    for (int i = 0; i < DEPTH + 2; i++) begin
      push(400 + i);
    end
    chk("R8 full", int'(full), 1);
    chk("R8 count", int'(count), DEPTH - 1);
    disconnect = 1'b1; cyc(); disconnect = 1'b0;
    chk("R8 rewind at full count", int'(count), DEPTH);
    chk("R8 rewind at full flag", int'(full), 1);
    cyc();
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 drain order", int'(out_data), 400 + i);
      accept = 1'b1; cyc();
    end
    accept = 1'b0;
    chk("R2 extra words dropped", int'(out_valid), 0);
    chk("R8 empty", int'(empty), 1);
  endtask

  task automatic t_flush();
    clean();
    push(501); push(502); push(503);
    flush = 1'b1; accept = 1'b1; disconnect = 1'b1; cyc(); idle_inputs();
    chk("R7 valid cleared", int'(out_valid), 0);
    chk("R7 count cleared", int'(count), 0);
    cyc();
    chk("R7 stays empty", int'(out_valid), 0);
    push(504);
    flush = 1'b1; wr_en = 1'b1; wr_data = DATA_W'(505); cyc(); idle_inputs();
    chk("R7 same-cycle write kept", int'(count), 1);
    cyc();
    chk("R7 kept word out", int'(out_data), 505);
  endtask

  task automatic t_wrap();
    clean();
    for (int k = 0; k < 3 * DEPTH + 3; k++) begin
      push(600 + k);
      cyc();
      chk("R9 wrap order", int'(out_data), 600 + k);
      accept = 1'b1; cyc(); accept = 1'b0;
    end
    chk("R9 wrap drained", int'(out_valid), 0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    wr_data  = '0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    t_reset();
    t_order();
    t_rewind();
    t_ignored();
    t_full();
    t_flush();
    t_wrap();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule